// File: doc/BRIEF.md
# Thirty-Two Pin General-Purpose I/O Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port on a small word-wide register bus. Software writes an output value and a direction mask. Each pin with its direction bit set drives its stored value onto the pad. The external level of every pad is synchronized and can be read back whatever the direction.

Each pin also watches its synchronized input for one of four conditions: low level, high level, rising edge or falling edge. A separate per-pin bit replaces that condition with "either edge". Detected conditions land in a sticky status register that software clears by writing ones. An enable mask selects which status bits drive the single interrupt line.

The eight word registers sit at these byte offsets:

| Offset | Register |
|--------|----------|
| 0x00 | output value |
| 0x04 | direction |
| 0x08 | pad level, read-only |
| 0x0C | condition, low pins |
| 0x10 | condition, high pins |
| 0x14 | interrupt enable mask |
| 0x18 | status |
| 0x1C | either-edge select |

Address bits [1:0] are ignored, and bit n of every per-pin register belongs to pin n.

Top module: `gpio_port`

## Requirements
- R1: While reset is held, every register reads zero, and `pad_out`, `pad_oe` and `irq` are zero.
- R2: The output value (0x00) and direction (0x04) registers read back what was written. `pad_oe` equals the direction register. `pad_out[n]` equals the output-value bit when direction bit n is 1, and 0 otherwise.
- R3: Offset 0x08 returns `pad_in` as it was two clock edges earlier, for input and output pins alike. Writes to 0x08 change nothing.
- R4: Pin n below 16 takes its 2-bit condition from bits [2n+1:2n] of 0x0C. Pin n from 16 up takes it from bits [2(n-16)+1:2(n-16)] of 0x10. The encoding is 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R5: An edge condition sets its status bit once per matching transition of the synchronized input. The bit stays set after the input settles.
- R6: A level condition sets its status bit on every cycle the level holds, so a bit cleared while its level is still present is set again.
- R7: When either-edge bit n (0x1C) is 1, pin n sets status on every rising and every falling transition, and its 2-bit condition is ignored.
- R8: Writing 0x18 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R9: `irq` is 1 exactly when some bit is set in both status and mask. Status bits of masked-off pins are still recorded.
- R10: When a condition sets a status bit in the same cycle that a write clears it, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | External pad levels, asynchronous |
| pad_out | output | 32 | Driven pad value |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A condition setting a status bit and a software clear of that same bit can land on the same clock edge. The bench provokes this by holding a high-level condition active on one pin while writing a one to that bit. It then expects the bit, and with it the interrupt, to still be set on the following read. Dropping the pad afterwards and clearing again must then leave the bit at zero. This separates "set wins" from a stale bit that never clears.

// File: rtl/gpio_port.sv
module gpio_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe,
  output logic        irq
);
  localparam int NPIN = 32;
  localparam int HALF = NPIN / 2;
  localparam logic [2:0] A_DOUT = 3'd0, A_DIR = 3'd1, A_PAD = 3'd2, A_CLO = 3'd3,
                         A_CHI = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_BOTH = 3'd7;

  logic [NPIN-1:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q, both_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q;
  logic [NPIN-1:0] rise, fall, trig;
  logic [2:0] word;
  logic wr;

  assign word = bus_addr[4:2];
  assign wr   = bus_en && bus_we;
  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] cond;
    if (i < HALF) begin : g_lo
      assign cond = cfg_lo_q[2*i +: 2];
    end else begin : g_hi
      assign cond = cfg_hi_q[2*(i-HALF) +: 2];
    end
    assign trig[i] = both_q[i]    ? (rise[i] | fall[i]) :
                     cond == 2'd0 ? ~sync2_q[i] :
                     cond == 2'd1 ?  sync2_q[i] :
                     cond == 2'd2 ?  rise[i] : fall[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; dir_q <= '0; cfg_lo_q <= '0; cfg_hi_q <= '0;
      mask_q <= '0; stat_q <= '0; both_q <= '0;
      sync1_q <= '0; sync2_q <= '0; prev_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (wr && word == A_DOUT) dout_q   <= bus_wdata;
      if (wr && word == A_DIR)  dir_q    <= bus_wdata;
      if (wr && word == A_CLO)  cfg_lo_q <= bus_wdata;
      if (wr && word == A_CHI)  cfg_hi_q <= bus_wdata;
      if (wr && word == A_MASK) mask_q   <= bus_wdata;
      if (wr && word == A_BOTH) both_q   <= bus_wdata;
      stat_q <= (stat_q & ~((wr && word == A_STAT) ? bus_wdata : '0)) | trig;
    end
  end

  always_comb begin
    case (word)
      A_DOUT:  bus_rdata = dout_q;
      A_DIR:   bus_rdata = dir_q;
      A_PAD:   bus_rdata = sync2_q;
      A_CLO:   bus_rdata = cfg_lo_q;
      A_CHI:   bus_rdata = cfg_hi_q;
      A_MASK:  bus_rdata = mask_q;
      A_STAT:  bus_rdata = stat_q;
      default: bus_rdata = both_q;
    endcase
  end

  assign pad_out = dout_q & dir_q;
  assign pad_oe  = dir_q;
  assign irq     = |(stat_q & mask_q);

  // R8
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && word == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == A_STAT && |trig) |=> ((stat_q & $past(trig)) == $past(trig)));

  // R7
  both_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |((sync2_q ^ prev_q) & both_q) |=>
      ((stat_q & $past((sync2_q ^ prev_q) & both_q)) == $past((sync2_q ^ prev_q) & both_q)));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr && (word == A_STAT || word == A_MASK))) |=> irq);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic irq;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  bit rd_valid = 1'b0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // kind: 0 = bus read, 1 = pad_out, 2 = pad_oe, 3 = irq
  task automatic chk(input int kind, input logic [4:0] addr, input logic [31:0] exp,
                     input string tag);
    item_t it;
    @(negedge clk);
    bus_en = 1'b0; bus_addr = addr;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    rd_valid = 1'b1;
    @(posedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic wr(input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    @(posedge clk);
    #1 bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (rd_valid && sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = pad_out;
          2: act = pad_oe;
          default: act = {31'd0, irq};
        endcase
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 50000);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    tick(2);
    // R1 reset state
    chk(0, 5'h00, 32'h0, "R1 data");
    chk(0, 5'h04, 32'h0, "R1 dir");
    chk(0, 5'h18, 32'h0, "R1 status");
    chk(0, 5'h14, 32'h0, "R1 mask");
    chk(2, 5'h00, 32'h0, "R1 pad_oe");
    chk(3, 5'h00, 32'h0, "R1 irq");
    @(negedge clk); rst_n = 1'b1;
    tick(4);
    // R6 / R4: reset condition code 0 = low level, pads low
    chk(0, 5'h18, 32'hFFFF_FFFF, "R6 low level all pins");

    // R2
    wr(5'h00, 32'hA5A5_0F0F);
    wr(5'h04, 32'hFFFF_0000);
    chk(0, 5'h00, 32'hA5A5_0F0F, "R2 data readback");
    chk(0, 5'h04, 32'hFFFF_0000, "R2 dir readback");
    chk(1, 5'h00, 32'hA5A5_0000, "R2 pad_out");
    chk(2, 5'h00, 32'hFFFF_0000, "R2 pad_oe");

    // R3
    set_pad(32'h1234_5678);
    chk(0, 5'h08, 32'h0, "R3 pad after one edge");
    chk(0, 5'h08, 32'h1234_5678, "R3 pad after two edges");
    wr(5'h08, 32'hFFFF_FFFF);
    chk(0, 5'h08, 32'h1234_5678, "R3 pad write ignored");

    // edges: rising on 0-15, falling on 16-31
    set_pad(32'h0);
    tick(4);
    wr(5'h0C, 32'hAAAA_AAAA);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    chk(0, 5'h18, 32'h0, "R8 clear all");
    set_pad(32'hFFFF_FFFF);
    tick(3);
    chk(0, 5'h18, 32'h0000_FFFF, "R4 R5 rising on low half");
    tick(5);
    chk(0, 5'h18, 32'h0000_FFFF, "R5 sticky after edge");
    set_pad(32'h0);
    tick(3);
    chk(0, 5'h18, 32'hFFFF_FFFF, "R4 R5 falling on high half");

    // R9
    chk(3, 5'h00, 32'h0, "R9 masked no irq");
    wr(5'h14, 32'h0001_0000);
    chk(3, 5'h00, 32'h1, "R9 unmasked irq");
    wr(5'h18, 32'h0001_0000);
    chk(0, 5'h18, 32'hFFFE_FFFF, "R8 single bit clear");
    chk(3, 5'h00, 32'h0, "R9 irq drops after clear");

    // R6 / R10: pin 20 high level
    wr(5'h10, 32'hFFFF_FDFF);
    wr(5'h18, 32'hFFFF_FFFF);
    chk(0, 5'h18, 32'h0, "R8 clear before level");
    wr(5'h14, 32'h0010_0000);
    set_pad(32'h0010_0000);
    tick(3);
    chk(0, 5'h18, 32'h0010_0000, "R4 R6 high level pin 20");
    wr(5'h18, 32'h0010_0000);
    chk(0, 5'h18, 32'h0010_0000, "R10 set wins over clear");
    chk(3, 5'h00, 32'h1, "R10 irq held");
    set_pad(32'h0);
    tick(4);
    wr(5'h18, 32'h0010_0000);
    chk(0, 5'h18, 32'h0, "R6 level gone then clear");

    // R4 low half: pin 3 high level
    wr(5'h0C, 32'hAAAA_AA6A);
    set_pad(32'h0000_0008);
    tick(3);
    chk(0, 5'h18, 32'h0000_0008, "R4 high level pin 3");
    set_pad(32'h0);
    tick(4);
    chk(0, 5'h18, 32'h0000_0008, "R6 sticky after level");
    wr(5'h18, 32'h0000_0008);
    chk(0, 5'h18, 32'h0, "R8 clear pin 3");

    // R7: pin 0 either edge, pin 1 rising only
    wr(5'h0C, 32'hAAAA_AAAA);
    wr(5'h1C, 32'h0000_0001);
    set_pad(32'h0000_0003);
    tick(3);
    chk(0, 5'h18, 32'h0000_0003, "R7 rising both pins");
    tick(2);
    wr(5'h18, 32'hFFFF_FFFF);
    set_pad(32'h0);
    tick(3);
    chk(0, 5'h18, 32'h0000_0001, "R7 falling only on either-edge pin");

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule